// File: doc/BRIEF.md
# Incremental CRC-16 Engine

This block keeps a running 16-bit frame check value that software builds up one data item at a time over a small register port. Software first clears the engine through a control register. It then writes each data item to an input register and can read two things back at any point: how many items have been accepted, and the current check value.

Each accepted item updates the accumulator within a single clock cycle. The check value can be read on the cycle after the write. A fixed four-byte self-test lets software confirm the engine before it relies on it.

The engine uses the 16-bit CCITT polynomial in bit-reversed form, with an all-ones preset and an inverted output. This is the combination that reproduces the self-test answer.

Top module: `crc16_engine`

## Requirements
- R1: After reset, the item count reads 0. The result register reads 0x0000, which is the preset 0xFFFF after output inversion.
- R2: A write to the control register (address 0) with bit 15 set clears the item count to 0 and restores the accumulator preset. After it, the result register reads 0x0000.
- R3: A write to the control register with bit 15 clear changes neither the count nor the result.
- R4: Each write to the input register (address 1) adds one to the count. A control register read returns the count in bits 11:0 and zeros in bits 15:12.
- R5: Only bits 7:0 of an input write enter the check value. Bits 15:8 of the written word have no effect on the result.
- R6: Each input byte is folded in least significant bit first using polynomial 0x8408 (the reflected form of x^16+x^12+x^5+1). The result register (address 2) shows the accumulator XOR 0xFFFF from the cycle after the write.
- R7: After a clear and the inputs 0xCC, 0xF5, 0xF1, 0xA7, the count reads 4 and the result reads 0x51DF.
- R8: The count stops at 0xFFF. Further input writes leave it at 0xFFF but still update the check value.
- R9: Writes to the result register or to the spare address 3 change neither the count nor the result. Reads of address 3 return 0.
- R10: Reading any register has no side effect, and the state does not change on cycles without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the register selected by addr |
| addr | input | 2 | Register select: 0 control, 1 input, 2 result, 3 spare |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the register selected by addr (combinational) |

## Verification
The bench builds the engine with its default parameters: a 16-bit register port, a 12-bit count, 8 folded bits of a 12-bit input field, the reflected polynomial and the all-ones preset and inversion. With the 12-bit count, saturation is reached after about four thousand writes, so the bench drives it past the limit and checks the check value continues to follow the model there. The same settings make the self-test vector an exact match for 0x51DF. The bench also writes words with high bits set to show that only the low byte counts.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

   // Register map of the engine
   typedef enum logic [1:0] {
      RA_CTRL   = 2'd0,
      RA_DATA   = 2'd1,
      RA_RESULT = 2'd2,
      RA_SPARE  = 2'd3
   } reg_addr_e;

   localparam int unsigned ADDR_W = 2;

endpackage

// File: rtl/crc_byte_fold.sv
// Folds FOLD_W data bits into a CRC state in one combinational step.
module crc_byte_fold #(
   parameter int unsigned           CRC_W     = 16,
   parameter int unsigned           FOLD_W    = 8,
   parameter logic [CRC_W-1:0]      POLY      = 16'h8408,
   parameter bit                    LSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  state_i,
   input  logic [FOLD_W-1:0] data_i,
   output logic [CRC_W-1:0]  state_o
);

   if (FOLD_W == 0 || FOLD_W > CRC_W) begin : g_bad_fold
      $error("crc_byte_fold: FOLD_W must be 1..CRC_W");
   end

   if (LSB_FIRST) begin : g_reflected
      always_comb begin
         logic [CRC_W-1:0] s;
         logic             fb;
         s = state_i;
         for (int i = 0; i < FOLD_W; i++) begin
            fb = s[0] ^ data_i[i];
            s  = s >> 1;
            if (fb) s = s ^ POLY;
         end
         state_o = s;
      end
   end else begin : g_normal
      always_comb begin
         logic [CRC_W-1:0] s;
         logic             fb;
         s = state_i;
         for (int i = 0; i < FOLD_W; i++) begin
            fb = s[CRC_W-1] ^ data_i[FOLD_W-1-i];
            s  = s << 1;
            if (fb) s = s ^ POLY;
         end
         state_o = s;
      end
   end

endmodule

// File: rtl/crc_sat_count.sv
// Saturating up-counter with synchronous clear.
module crc_sat_count #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] CNT_MAX = '1;

   if (W == 0) begin : g_bad_w
      $error("crc_sat_count: W must be nonzero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc && count != CNT_MAX) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/crc_read_mux.sv
// Read-side register select, with the status fields zero-extended.
module crc_read_mux #(
   parameter int unsigned REG_W = 16,
   parameter int unsigned CRC_W = 16,
   parameter int unsigned CNT_W = 12
) (
   input  crc16_pkg::reg_addr_e addr,
   input  logic [CNT_W-1:0]     count,
   input  logic [CRC_W-1:0]     result,
   output logic [REG_W-1:0]     rdata
);

   import crc16_pkg::*;

   localparam int unsigned CNT_PAD = REG_W - CNT_W;
   localparam int unsigned CRC_PAD = REG_W - CRC_W;

   logic [REG_W-1:0] ctrl_view;
   logic [REG_W-1:0] result_view;

   if (CNT_PAD > 0) begin : g_cnt_pad
      assign ctrl_view = {{CNT_PAD{1'b0}}, count};
   end else begin : g_cnt_full
      assign ctrl_view = count;
   end

   if (CRC_PAD > 0) begin : g_crc_pad
      assign result_view = {{CRC_PAD{1'b0}}, result};
   end else begin : g_crc_full
      assign result_view = result;
   end

   always_comb begin
      unique case (addr)
         RA_CTRL:   rdata = ctrl_view;
         RA_RESULT: rdata = result_view;
         default:   rdata = '0;
      endcase
   end

endmodule

// File: rtl/crc16_engine.sv
// Register-mapped incremental CRC accumulator.
module crc16_engine #(
   parameter int unsigned      REG_W     = 16,
   parameter int unsigned      CRC_W     = 16,
   parameter int unsigned      CNT_W     = 12,
   parameter int unsigned      IN_W      = 12,
   parameter int unsigned      FOLD_W    = 8,
   parameter logic [CRC_W-1:0] POLY      = 16'h8408,
   parameter logic [CRC_W-1:0] PRESET    = 16'hFFFF,
   parameter logic [CRC_W-1:0] XOROUT    = 16'hFFFF,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata
);

   import crc16_pkg::*;

   localparam int unsigned CLR_BIT = REG_W - 1;

   if (REG_W < CRC_W) begin : g_bad_reg
      $error("crc16_engine: REG_W must hold the CRC");
   end
   if (REG_W <= CNT_W) begin : g_bad_cnt
      $error("crc16_engine: count field overlaps the clear bit");
   end
   if (IN_W < FOLD_W || IN_W > REG_W) begin : g_bad_in
      $error("crc16_engine: FOLD_W <= IN_W <= REG_W required");
   end

   reg_addr_e        sel;
   logic             do_clear;
   logic             do_feed;
   logic [IN_W-1:0]  in_field;
   logic [CRC_W-1:0] acc;
   logic [CRC_W-1:0] acc_next;
   logic [CNT_W-1:0] cnt;

   assign sel      = reg_addr_e'(addr);
   assign do_clear = wr_en && (sel == RA_CTRL) && wdata[CLR_BIT];
   assign do_feed  = wr_en && (sel == RA_DATA);
   assign in_field = wdata[IN_W-1:0];

   crc_byte_fold #(
      .CRC_W     (CRC_W),
      .FOLD_W    (FOLD_W),
      .POLY      (POLY),
      .LSB_FIRST (LSB_FIRST)
   ) u_fold (
      .state_i (acc),
      .data_i  (in_field[FOLD_W-1:0]),
      .state_o (acc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= PRESET;
      end else if (do_clear) begin
         acc <= PRESET;
      end else if (do_feed) begin
         acc <= acc_next;
      end
   end

   crc_sat_count #(
      .W (CNT_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (do_clear),
      .inc   (do_feed),
      .count (cnt)
   );

   crc_read_mux #(
      .REG_W (REG_W),
      .CRC_W (CRC_W),
      .CNT_W (CNT_W)
   ) u_rmux (
      .addr   (sel),
      .count  (cnt),
      .result (acc ^ XOROUT),
      .rdata  (rdata)
   );

endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk #(
   parameter int unsigned      REG_W  = 16,
   parameter int unsigned      CRC_W  = 16,
   parameter int unsigned      CNT_W  = 12,
   parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [REG_W-1:0] wdata,
   input logic [REG_W-1:0] rdata,
   input logic [CRC_W-1:0] acc,
   input logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CMAX = '1;

   AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0 && wdata[REG_W-1]) |=> (cnt == '0 && acc == PRESET)); // R2

   AST_CTRL_NOCLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0 && !wdata[REG_W-1]) |=> ($stable(cnt) && $stable(acc))); // R3

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1 && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1)); // R4

   AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == 2'd0) |-> (rdata[REG_W-1:CNT_W] == '0)); // R4

   AST_COUNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd1 && cnt == CMAX) |=> (cnt == CMAX)); // R8

   AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[1]) |=> ($stable(cnt) && $stable(acc))); // R9

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> ($stable(cnt) && $stable(acc))); // R10

endmodule

bind crc16_engine crc16_engine_chk #(
   .REG_W  (REG_W),
   .CRC_W  (CRC_W),
   .CNT_W  (CNT_W),
   .PRESET (PRESET)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .addr  (addr),
   .wdata (wdata),
   .rdata (rdata),
   .acc   (acc),
   .cnt   (cnt)
);

// File: tb/crc16_engine_tb.sv
`timescale 1ns/1ps
module crc16_engine_tb;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_DATA = 2'd1;
   localparam logic [1:0] A_RES  = 2'd2;
   localparam logic [1:0] A_SPR  = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] mdl = 16'hFFFF;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   event        ev_sample;

   always #10 clk = ~clk;

   crc16_engine u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata)
   );

   function automatic logic [15:0] ref_fold(logic [15:0] s, logic [7:0] b);
      logic [15:0] r;
      r = s ^ {8'h00, b};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
      return r;
   endfunction

   task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = A_CTRL; wdata = '0;
   endtask

   task automatic rd(logic [1:0] a, output logic [15:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   // Driver: updates the model, queues the expected result, then lets the monitor sample.
   task automatic feed(logic [15:0] d, string tag);
      mdl = ref_fold(mdl, d[7:0]);
      exp_q.push_back(mdl ^ 16'hFFFF);
      tag_q.push_back(tag);
      wr(A_DATA, d);
      addr = A_RES;
      #1;
      -> ev_sample;
      #1;
   endtask

   task automatic clear_engine();
      wr(A_CTRL, 16'h8000);
      mdl = 16'hFFFF;
   endtask

   // Monitor: pops the scoreboard on every sample request.
   always begin
      @(ev_sample);
      if (exp_q.size() == 0) begin
         n_checks++; n_fail++;
         $display("FAIL R6 scoreboard underflow: got %h expected none", rdata);
      end else begin
         check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v, r0, c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v); check("R1 count after reset", v, 16'h0000);
      rd(A_RES, v);  check("R1 result after reset", v, 16'h0000);

      // R7 self-test vector, also R6 running results
      clear_engine();
      feed(16'h00CC, "R6 running after 0xCC");
      feed(16'h00F5, "R6 running after 0xF5");
      feed(16'h00F1, "R6 running after 0xF1");
      feed(16'h00A7, "R6 running after 0xA7");
      rd(A_CTRL, v); check("R7 self-test count", v, 16'h0004);
      rd(A_RES, v);  check("R7 self-test result", v, 16'h51DF);
      check("R7 model agrees with constant", mdl ^ 16'hFFFF, 16'h51DF);

      // R10 repeated reads change nothing
      rd(A_RES, v); rd(A_CTRL, v); rd(A_RES, v);
      check("R10 result after idle reads", v, 16'h51DF);

      // R3 control write without the clear bit
      wr(A_CTRL, 16'h7FFF);
      rd(A_CTRL, v); check("R3 count kept", v, 16'h0004);
      rd(A_RES, v);  check("R3 result kept", v, 16'h51DF);

      // R9 writes to result and spare addresses
      wr(A_RES, 16'h1234);
      wr(A_SPR, 16'hFFFF);
      rd(A_CTRL, v); check("R9 count kept", v, 16'h0004);
      rd(A_RES, v);  check("R9 result kept", v, 16'h51DF);
      rd(A_SPR, v);  check("R9 spare reads zero", v, 16'h0000);

      // R2 clear
      clear_engine();
      rd(A_CTRL, v); check("R2 count cleared", v, 16'h0000);
      rd(A_RES, v);  check("R2 result cleared", v, 16'h0000);

      // R5 high bits ignored: 0xFFCC must act like 0xCC
      feed(16'hFFCC, "R5 high bits ignored 0xFFCC");
      feed(16'h0F00, "R5 high bits ignored 0x0F00");
      feed(16'hA55A, "R6 pattern 0x5A");
      rd(A_CTRL, v); check("R4 count three", v, 16'h0003);

      // R6 more patterns
      clear_engine();
      for (int i = 0; i < 16; i++) feed(16'((i * 37 + 11) & 16'hFF), "R6 pattern sweep");

      // R8 saturation
      clear_engine();
      for (int i = 0; i < 4100; i++) begin
         mdl = ref_fold(mdl, 8'(i));
         wr(A_DATA, 16'(i));
      end
      rd(A_CTRL, c0); check("R8 count saturated", c0, 16'h0FFF);
      rd(A_RES, r0);  check("R8 result after saturation", r0, mdl ^ 16'hFFFF);
      feed(16'h0033, "R8 result still updates when saturated");
      rd(A_CTRL, v); check("R8 count stays at max", v, 16'h0FFF);

      // R4 upper control bits read zero
      check("R4 ctrl upper bits zero", v & 16'hF000, 16'h0000);

      #5;
      if (exp_q.size() != 0) begin
         n_checks++; n_fail++;
         $display("FAIL R6 scoreboard leftover: got %0d expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule